// File: doc/BRIEF.md
# Four-mode funnel shifter

This block shifts or rotates one data word in a single combinational pass. Every mode goes through the same datapath. The operand is first placed into a double-width word, an upper half and a lower half, and an effective amount is chosen. That double word then goes through a right-shifting ladder of two-input multiplexer levels, and the low half of the ladder output is the result. The four operations differ only in what goes into the two halves and in the amount that reaches the ladder.

The operation mode has two bits:

- 00 shifts right logically.
- 01 shifts right arithmetically.
- 10 rotates right.
- 11 shifts left logically.

For a left shift the operand sits in the upper half and the ladder moves it right by the complement of the requested amount. The block holds no state, and the result follows the inputs within the same cycle.

Top module: `funnel_shifter`

## Requirements
- R1: With mode 00 and amount n (1..31), result equals the operand moved n places toward bit 0, with the top n bits filled with 0.
- R2: With mode 01 and amount n, result equals the operand moved n places toward bit 0, with the top n bits filled with copies of operand bit 31.
- R3: With mode 10 and amount n, bit k of the result equals operand bit (k+n) mod 32.
- R4: With mode 11 and amount n (1..31), result equals the operand moved n places toward bit 31, with the low n bits filled with 0.
- R5: An amount of 0 returns the operand unchanged in each of the four modes.
- R6: The mode encoding is 00 logical right, 01 arithmetic right, 10 rotate right, 11 logical left. Changing only the mode changes the result to that mode's value.
- R7: The amount is a 5-bit unsigned field. Every value from 0 to 31, including the extreme 31, gives the mode's defined result.
- R8: The result is a combinational function of the inputs and settles without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Operand word |
| shamt | input | 5 | Shift or rotate amount, unsigned |
| mode | input | 2 | Operation select: 00 logical right, 01 arithmetic right, 10 rotate right, 11 logical left |
| result | output | 32 | Shifted or rotated operand |

## Verification
Every amount from 0 to 31 is applied in all four modes to a set of chosen operands:

- A lone set bit at each end shows where a bit lands and whether it wraps around.
- An all-ones word and a word with only the sign bit set tell the zero fill apart from the sign fill.
- An alternating pattern exposes a wrong ladder level, since a wrong level shifts the pattern by an odd or mismatched distance.

A pseudo-random run then mixes modes, amounts and operands to catch faults between the stages. A mode-only sweep holds the operand and the amount fixed, which shows that each code selects its own operation.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

    localparam int WORD_W  = 32;
    localparam int SHAMT_W = $clog2(WORD_W);

    typedef enum logic [1:0] {
        SH_RIGHT_LOG   = 2'b00,
        SH_RIGHT_ARITH = 2'b01,
        SH_ROTATE      = 2'b10,
        SH_LEFT_LOG    = 2'b11
    } shift_mode_e;

    // Effective right-extraction amount for a left shift: (WORD - n) mod WORD
    function automatic logic [SHAMT_W-1:0] left_to_right_amt(input logic [SHAMT_W-1:0] n);
        return SHAMT_W'(~n + 1'b1);
    endfunction

endpackage

// File: rtl/funnel_operand_map.sv
module funnel_operand_map
    import funnel_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  op_a,
    input  logic [AW-1:0] shamt,
    input  shift_mode_e   mode,
    output logic [W-1:0]  upper,
    output logic [W-1:0]  lower,
    output logic [AW-1:0] eff_amt
);

    always_comb begin
        upper   = '0;
        lower   = op_a;
        eff_amt = shamt;
        unique case (mode)
            SH_RIGHT_LOG: begin
                upper = '0;
                lower = op_a;
            end
            SH_RIGHT_ARITH: begin
                upper = {W{op_a[W-1]}};
                lower = op_a;
            end
            SH_ROTATE: begin
                upper = op_a;
                lower = op_a;
            end
            SH_LEFT_LOG: begin
                upper   = op_a;
                // a zero amount would need an extraction of W, so feed the operand low
                lower   = (shamt == '0) ? op_a : '0;
                eff_amt = AW'(left_to_right_amt(SHAMT_W'(shamt)));
            end
            default: begin
                upper = '0;
                lower = op_a;
            end
        endcase
    end

endmodule

// File: rtl/funnel_stage.sv
module funnel_stage #(
    parameter int DW    = 64,
    parameter int SHIFT = 1
) (
    input  logic          sel,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    always_comb begin
        if (sel)
            dout = {{SHIFT{1'b0}}, din[DW-1:SHIFT]};
        else
            dout = din;
    end

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
    import funnel_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  op_a,
    input  logic [AW-1:0] shamt,
    input  logic [1:0]    mode,
    output logic [W-1:0]  result
);

    localparam int DW = 2 * W;

    logic [W-1:0]  upper;
    logic [W-1:0]  lower;
    logic [AW-1:0] eff_amt;
    logic [DW-1:0] ladder [AW+1];

    funnel_operand_map #(.W(W), .AW(AW)) u_map (
        .op_a    (op_a),
        .shamt   (shamt),
        .mode    (shift_mode_e'(mode)),
        .upper   (upper),
        .lower   (lower),
        .eff_amt (eff_amt)
    );

    assign ladder[0] = {upper, lower};

    generate
        for (genvar lvl = 0; lvl < AW; lvl++) begin : g_level
            funnel_stage #(.DW(DW), .SHIFT(1 << lvl)) u_stage (
                .sel  (eff_amt[lvl]),
                .din  (ladder[lvl]),
                .dout (ladder[lvl+1])
            );
        end
    endgenerate

    assign result = ladder[AW][W-1:0];

    always_comb begin
        if (shamt == '0)
            AST_ZERO_IDENTITY: assert (result == op_a) else $error("zero amount altered operand"); // R5
        if (mode == 2'b01)
            AST_ARITH_SIGN: assert (result[W-1] == op_a[W-1]) else $error("sign bit lost"); // R2
        if (mode == 2'b00 && shamt != '0)
            AST_LOGIC_TOP_ZERO: assert (result[W-1] == 1'b0) else $error("logical right top bit set"); // R1
        if (mode == 2'b11 && shamt != '0)
            AST_LEFT_LOW_ZERO: assert (result[0] == 1'b0) else $error("left shift low bit set"); // R4
        if (mode == 2'b10)
            AST_ROTATE_WEIGHT: assert ($countones(result) == $countones(op_a)) else $error("rotate lost bits"); // R3
    end

endmodule

// File: tb/funnel_shifter_test.sv
module funnel_shifter_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [4:0]  shamt = '0;
    logic [1:0]  mode = '0;
    logic [31:0] result;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    funnel_shifter uut (
        .op_a   (op_a),
        .shamt  (shamt),
        .mode   (mode),
        .result (result)
    );

    function automatic logic [31:0] ref_model(input logic [31:0] a, input int n, input logic [1:0] m);
        logic [63:0] dbl;
        case (m)
            2'b00: return a >> n;
            2'b01: return 32'($signed(a) >>> n);
            2'b10: begin
                dbl = {a, a};
                dbl = dbl >> n;
                return dbl[31:0];
            end
            default: return a << n;
        endcase
    endfunction

    function automatic string tag_of(input int n, input logic [1:0] m);
        if (n == 0) return "R5";
        case (m)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [31:0] exp);
        n_checks++;
        if (result !== exp) begin
            n_fails++;
            $display("FAIL %s: a=%h n=%0d mode=%b got %h expected %h",
                     tag, op_a, shamt, mode, result, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input int n, input logic [1:0] m, input string tag);
        @(negedge clk);
        op_a  = a;
        shamt = 5'(n);
        mode  = m;
        #(CLK_PERIOD/4);
        compare(tag, ref_model(a, n, m));
    endtask

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] pats [6];
        logic [31:0] lfsr;
        pats[0] = 32'h0000_0001;
        pats[1] = 32'h8000_0000;
        pats[2] = 32'hFFFF_FFFF;
        pats[3] = 32'hAAAA_5555;
        pats[4] = 32'h1234_5678;
        pats[5] = 32'h7FFF_FFFE;

        repeat (2) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs give zero (R5)
        @(negedge clk);
        compare("R5", 32'h0);

        // exhaustive amounts per mode; includes 31 for R7
        for (int p = 0; p < 6; p++)
            for (int m = 0; m < 4; m++)
                for (int n = 0; n < 32; n++)
                    apply(pats[p], n, 2'(m), tag_of(n, 2'(m)));

        // R6: only the mode changes
        for (int m = 0; m < 4; m++)
            apply(32'hC003_00F1, 7, 2'(m), "R6");

        // R7: largest amount in every mode
        for (int m = 0; m < 4; m++)
            apply(32'h8000_0001, 31, 2'(m), "R7");

        // R8: result settles without a clock edge (change inputs mid-phase)
        @(posedge clk);
        #1;
        op_a = 32'hDEAD_BEEF; shamt = 5'd4; mode = 2'b10;
        #1;
        compare("R8", ref_model(32'hDEAD_BEEF, 4, 2'b10));

        // pseudo-random mix
        lfsr = 32'hACE1_2345;
        for (int k = 0; k < 3000; k++) begin
            int n;
            logic [1:0] m;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            n = int'(lfsr[4:0] ^ lfsr[20:16]);
            m = lfsr[9:8] ^ lfsr[27:26];
            apply(lfsr ^ {lfsr[15:0], lfsr[31:16]}, n, m, tag_of(n, m));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule